// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block sits between a simple register-request interface and a byte-level I2C engine. A single `go` strobe asks for one register of a slave device to be written or read. The block turns the request into an ordered series of byte commands for the engine and steps through that series. It issues one command at a time and waits for the engine's completion pulse before moving to the next. When the sequence ends it pulses `done`. On a read, the received byte is available on `rd_data` in that same cycle. If the slave fails to acknowledge a byte it is required to acknowledge, the block raises `err`.

A write takes three commands. A read takes four: the register pointer is first set through a write-direction addressing phase, and the data is then fetched after a repeated START. Every missing acknowledge during addressing leaves through one shared exit. That exit issues a STOP-only command and then ends the sequence with the error flag set. The command outputs are a pure function of the sequencer state and of the request captured when `go` was accepted.

Top module: `i2c_reg_seq`

## Requirements
- R1: After reset, `cmd_valid`, `done` and `err` are 0, `cmd_op` is 0 (none), and the block accepts a `go` strobe.
- R2: Every command carrying `cmd_start`=1 has `cmd_byte` = {7-bit slave address, direction bit}, with the direction bit in bit 0 (0 = write, 1 = read).
- R3: A write (`rd_nwr`=0) issues, in order: send (`cmd_op`=1) with start of the address byte with bit 0 = 0, send of the register address, then send of the write data with `cmd_stop`=1.
- R4: A read (`rd_nwr`=1) issues, in order: send with start of the address byte with bit 0 = 0, send of the register address, send with start (repeated START) of the address byte with bit 0 = 1, then receive (`cmd_op`=2) with `cmd_stop`=1, answered with NACK.
- R5: A command is presented with `cmd_valid`=1 and stays unchanged until `eng_done` is sampled high. The block advances only on `eng_done`.
- R6: If `eng_ack`=0 at completion of either address byte or of the register byte, the next command is STOP-only (`cmd_op`=3, `cmd_start`=0, `cmd_stop`=1). After its completion the sequence ends with `err`=1.
- R7: If the write data byte is not acknowledged, no further command is issued. The sequence ends at once with `err`=1, because STOP went out with that byte.
- R8: `done` is a single-cycle pulse, one cycle after the final `eng_done`, with `cmd_valid`=0. On a successful read, `rd_data` equals the received byte in that cycle.
- R9: A `go` strobe during an active sequence is ignored. The sequence continues with its captured request, and no new sequence starts after it.
- R10: `err` stays set after an aborted sequence and clears only when the next `go` is accepted. A successful sequence ends with `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Request strobe, taken only when idle |
| rd_nwr | input | 1 | 1 = register read, 0 = register write |
| dev_addr | input | 7 | Slave address |
| reg_addr | input | 8 | Register address inside the slave |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte read from the slave |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Missing-acknowledge flag |
| cmd_valid | output | 1 | A command is presented to the engine |
| cmd_op | output | 2 | 0 none, 1 send, 2 receive with NACK, 3 STOP only |
| cmd_start | output | 1 | Precede the byte with START / repeated START |
| cmd_stop | output | 1 | Follow the command with STOP |
| cmd_byte | output | 8 | Byte to send (0 for receive and STOP only) |
| eng_done | input | 1 | Engine finished the current command |
| eng_ack | input | 1 | Slave acknowledged the byte just sent |
| eng_rx | input | 8 | Byte received by the engine |

## Verification
Some properties are checked on every cycle by assertions: a presented command stays unchanged until the engine completes it, `done` never lasts two cycles and never coincides with a command, a receive command always carries STOP, and `err` only drops on a `go`. The exact order and contents of the write and read command series, the choice between the STOP-only exit and the direct exit after a refused data byte, and the returned read byte can only be shown by the bench's scenarios. The same holds for whether a `go` during a busy sequence leaves the captured request untouched.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int SADDR_W = 7;
  localparam int BYTE_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR_W, ST_REG, ST_DATA_W, ST_ADDR_R, ST_DATA_R, ST_ABORT, ST_FINISH
  } seq_state_t;

  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_SEND = 2'd1;
  localparam logic [1:0] OP_RECV = 2'd2;
  localparam logic [1:0] OP_STOP = 2'd3;

  function automatic logic [BYTE_W-1:0] addr_byte(input logic [SADDR_W-1:0] a, input logic rd);
    return {a, rd};
  endfunction

  function automatic logic acks_required(input seq_state_t s);
    return (s == ST_ADDR_W) || (s == ST_REG) || (s == ST_DATA_W) || (s == ST_ADDR_R);
  endfunction
endpackage

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       rd_req,
  input  logic       eng_done,
  input  logic       eng_ack,
  output seq_state_t state,
  output logic       nack_seen
);
  seq_state_t state_q, state_d;

  assign nack_seen = eng_done && !eng_ack && acks_required(state_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_ADDR_W;
      ST_ADDR_W: if (eng_done) state_d = eng_ack ? ST_REG : ST_ABORT;
      ST_REG:    if (eng_done) state_d = !eng_ack ? ST_ABORT : (rd_req ? ST_ADDR_R : ST_DATA_W);
      ST_DATA_W: if (eng_done) state_d = ST_FINISH;
      ST_ADDR_R: if (eng_done) state_d = eng_ack ? ST_DATA_R : ST_ABORT;
      ST_DATA_R: if (eng_done) state_d = ST_FINISH;
      ST_ABORT:  if (eng_done) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/i2c_seq_capture.sv
module i2c_seq_capture
  import i2c_seq_pkg::*;
#(
  parameter int AW = SADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  seq_state_t    state,
  input  logic          eng_done,
  input  logic          nack_seen,
  input  logic [BW-1:0] eng_rx,
  input  logic          rd_nwr,
  input  logic [AW-1:0] dev_addr,
  input  logic [BW-1:0] reg_addr,
  input  logic [BW-1:0] wr_data,
  output logic          accept,
  output logic          rd_q,
  output logic [AW-1:0] dev_q,
  output logic [BW-1:0] reg_q,
  output logic [BW-1:0] wdat_q,
  output logic [BW-1:0] rd_data,
  output logic          err
);
  assign accept = go && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      wdat_q  <= '0;
      rd_data <= '0;
      err     <= 1'b0;
    end else begin
      if (accept) begin
        rd_q   <= rd_nwr;
        dev_q  <= dev_addr;
        reg_q  <= reg_addr;
        wdat_q <= wr_data;
        err    <= 1'b0;
      end else if (nack_seen) begin
        err    <= 1'b1;
      end
      if (state == ST_DATA_R && eng_done) rd_data <= eng_rx;
    end
  end
endmodule

// File: rtl/i2c_seq_cmd.sv
module i2c_seq_cmd
  import i2c_seq_pkg::*;
#(
  parameter int AW = SADDR_W,
  parameter int BW = BYTE_W
) (
  input  seq_state_t    state,
  input  logic [AW-1:0] dev_q,
  input  logic [BW-1:0] reg_q,
  input  logic [BW-1:0] wdat_q,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic          cmd_start,
  output logic          cmd_stop,
  output logic [BW-1:0] cmd_byte,
  output logic          done
);
  always_comb begin
    cmd_op    = OP_NONE;
    cmd_start = 1'b0;
    cmd_stop  = 1'b0;
    cmd_byte  = '0;
    unique case (state)
      ST_ADDR_W: begin cmd_op = OP_SEND; cmd_start = 1'b1; cmd_byte = addr_byte(dev_q, 1'b0); end
      ST_REG:    begin cmd_op = OP_SEND; cmd_byte = reg_q; end
      ST_DATA_W: begin cmd_op = OP_SEND; cmd_stop = 1'b1; cmd_byte = wdat_q; end
      ST_ADDR_R: begin cmd_op = OP_SEND; cmd_start = 1'b1; cmd_byte = addr_byte(dev_q, 1'b1); end
      ST_DATA_R: begin cmd_op = OP_RECV; cmd_stop = 1'b1; end
      ST_ABORT:  begin cmd_op = OP_STOP; cmd_stop = 1'b1; end
      default:   ;
    endcase
  end

  assign cmd_valid = (cmd_op != OP_NONE);
  assign done      = (state == ST_FINISH);
endmodule

// File: rtl/i2c_reg_seq.sv
module i2c_reg_seq
  import i2c_seq_pkg::*;
#(
  parameter int AW = SADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          rd_nwr,
  input  logic [AW-1:0] dev_addr,
  input  logic [BW-1:0] reg_addr,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] rd_data,
  output logic          done,
  output logic          err,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic          cmd_start,
  output logic          cmd_stop,
  output logic [BW-1:0] cmd_byte,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [BW-1:0] eng_rx
);
  seq_state_t    state;
  logic          accept, nack_seen, rd_q;
  logic [AW-1:0] dev_q;
  logic [BW-1:0] reg_q, wdat_q;

  i2c_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rd_req(rd_q),
    .eng_done(eng_done), .eng_ack(eng_ack), .state(state), .nack_seen(nack_seen)
  );

  i2c_seq_capture #(.AW(AW), .BW(BW)) u_cap (
    .clk(clk), .rst_n(rst_n), .go(go), .state(state), .eng_done(eng_done),
    .nack_seen(nack_seen), .eng_rx(eng_rx), .rd_nwr(rd_nwr), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .wr_data(wr_data), .accept(accept), .rd_q(rd_q),
    .dev_q(dev_q), .reg_q(reg_q), .wdat_q(wdat_q), .rd_data(rd_data), .err(err)
  );

  i2c_seq_cmd #(.AW(AW), .BW(BW)) u_cmd (
    .state(state), .dev_q(dev_q), .reg_q(reg_q), .wdat_q(wdat_q),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_byte(cmd_byte), .done(done)
  );
endmodule

// File: rtl/i2c_reg_seq_chk.sv
module i2c_reg_seq_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          eng_done,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic          cmd_stop,
  input logic [BW-1:0] cmd_byte,
  input logic          done,
  input logic          err
);
  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !eng_done) |=> (cmd_valid && $stable(cmd_byte) && $stable(cmd_op)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  // R4
  recv_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |-> cmd_stop);

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(go));
endmodule

bind i2c_reg_seq i2c_reg_seq_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .eng_done(eng_done), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_stop(cmd_stop), .cmd_byte(cmd_byte), .done(done), .err(err)
);

// File: tb/tb_i2c_reg_seq.sv
module tb_i2c_reg_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0, rd_nwr = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [7:0] reg_addr = '0, wr_data = '0, eng_rx = '0;
  logic       eng_done = 1'b0, eng_ack = 1'b0;
  logic [7:0] rd_data, cmd_byte;
  logic       done, err, cmd_valid, cmd_start, cmd_stop;
  logic [1:0] cmd_op;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_reg_seq dut (
    .clk(clk), .rst_n(rst_n), .go(go), .rd_nwr(rd_nwr), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data), .done(done), .err(err),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_byte(cmd_byte), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rx(eng_rx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(input bit rd, input logic [6:0] a, input logic [7:0] r, input logic [7:0] d);
    rd_nwr = rd; dev_addr = a; reg_addr = r; wr_data = d; go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  // Acts as the byte engine for one command: checks it, holds it, completes it.
  task automatic serve(input string req, input logic [1:0] op, input logic st, input logic sp,
                       input logic [7:0] b, input logic ack, input logic [7:0] rx,
                       input int hold, input bit busy_go);
    int n = 0;
    while (!cmd_valid && n < 20) begin @(negedge clk); n++; end
    chk(cmd_valid, req, cmd_valid, 1);
    chk({cmd_op, cmd_start, cmd_stop} == {op, st, sp}, req, {cmd_op, cmd_start, cmd_stop}, {op, st, sp});
    chk(cmd_byte == b, req, cmd_byte, b);
    for (int i = 0; i < hold; i++) begin
      if (busy_go && i == 0) begin
        go = 1'b1; rd_nwr = ~rd_nwr; dev_addr = 7'h7F; reg_addr = 8'hEE; wr_data = 8'h11;
      end
      @(negedge clk);
      go = 1'b0;
      chk(cmd_valid && cmd_byte == b && cmd_op == op, "R5 held command", cmd_byte, b);
    end
    eng_ack = ack; eng_rx = rx; eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0; eng_ack = 1'b0;
  endtask

  task automatic finish_chk(input string req, input bit e, input bit rchk, input logic [7:0] rexp);
    chk(done == 1'b1 && cmd_valid == 1'b0, {req, " done"}, {done, cmd_valid}, 2'b10);
    chk(err == e, {req, " err"}, err, e);
    if (rchk) chk(rd_data == rexp, "R8 rd_data", rd_data, rexp);
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", done, 0);
  endtask

  task automatic t_reset();
    chk(!cmd_valid && !done && !err && cmd_op == 2'd0, "R1 reset",
        {cmd_valid, done, err, cmd_op}, 0);
  endtask

  task automatic t_write();
    request(0, 7'h4C, 8'h12, 8'hA5);
    serve("R3 addr W / R2", 2'd1, 1, 0, 8'h98, 1, 0, 2, 0);
    serve("R3 reg", 2'd1, 0, 0, 8'h12, 1, 0, 0, 0);
    serve("R3 data+stop", 2'd1, 0, 1, 8'hA5, 1, 0, 3, 0);
    finish_chk("R3", 0, 0, 0);
  endtask

  task automatic t_read();
    request(1, 7'h21, 8'h07, 8'h00);
    serve("R4 addr W / R2", 2'd1, 1, 0, 8'h42, 1, 0, 0, 0);
    serve("R4 reg", 2'd1, 0, 0, 8'h07, 1, 0, 1, 0);
    serve("R4 rep start R / R2", 2'd1, 1, 0, 8'h43, 1, 0, 0, 0);
    serve("R4 recv nack stop", 2'd2, 0, 1, 8'h00, 0, 8'h3C, 2, 0);
    finish_chk("R4", 0, 1, 8'h3C);
  endtask

  task automatic t_nack_first();
    request(0, 7'h50, 8'h01, 8'h02);
    serve("R6 addr", 2'd1, 1, 0, 8'hA0, 0, 0, 0, 0);
    serve("R6 stop only", 2'd3, 0, 1, 8'h00, 1, 0, 1, 0);
    finish_chk("R6", 1, 0, 0);
    repeat (3) @(negedge clk);
    chk(err == 1'b1 && !cmd_valid, "R10 err held", err, 1);
  endtask

  task automatic t_nack_reg_then_clear();
    request(1, 7'h33, 8'h44, 8'h00);
    @(negedge clk);
    chk(err == 1'b0, "R10 err cleared on go", err, 0);
    serve("R6 addr ok", 2'd1, 1, 0, 8'h66, 1, 0, 0, 0);
    serve("R6 reg nack", 2'd1, 0, 0, 8'h44, 0, 0, 0, 0);
    serve("R6 stop only after reg", 2'd3, 0, 1, 8'h00, 1, 0, 0, 0);
    finish_chk("R6", 1, 0, 0);
  endtask

  task automatic t_nack_addr_r();
    request(1, 7'h0A, 8'hFF, 8'h00);
    serve("R6 addr W", 2'd1, 1, 0, 8'h14, 1, 0, 0, 0);
    serve("R6 reg", 2'd1, 0, 0, 8'hFF, 1, 0, 0, 0);
    serve("R6 addr R nack", 2'd1, 1, 0, 8'h15, 0, 0, 0, 0);
    serve("R6 stop only after addr R", 2'd3, 0, 1, 8'h00, 1, 0, 0, 0);
    finish_chk("R6", 1, 0, 0);
  endtask

  task automatic t_nack_data();
    request(0, 7'h12, 8'h34, 8'h56);
    serve("R7 addr", 2'd1, 1, 0, 8'h24, 1, 0, 0, 0);
    serve("R7 reg", 2'd1, 0, 0, 8'h34, 1, 0, 0, 0);
    serve("R7 data nack", 2'd1, 0, 1, 8'h56, 0, 0, 0, 0);
    finish_chk("R7 no extra stop", 1, 0, 0);
  endtask

  task automatic t_busy_go();
    request(0, 7'h5A, 8'h9C, 8'hC3);
    serve("R9 addr", 2'd1, 1, 0, 8'hB4, 1, 0, 0, 0);
    serve("R9 reg with go", 2'd1, 0, 0, 8'h9C, 1, 0, 2, 1);
    serve("R9 data unchanged", 2'd1, 0, 1, 8'hC3, 1, 0, 0, 0);
    finish_chk("R9", 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(!cmd_valid && !done, "R9 no new sequence", cmd_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_nack_first();
    t_nack_reg_then_clear();
    t_nack_addr_r();
    t_nack_data();
    t_busy_go();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end
endmodule